// File: doc/BRIEF.md
# Error-Record Store Command Front End

The block is the register front end that software uses to drive a persistent error-record store. It exposes a 16-byte window holding two 64-bit registers: a command register and a mailbox register. Software stages operands in the mailbox and then writes a command code. The code can pick the pending operation, move a mailbox operand into internal state, copy internal state back into the mailbox, or start the pending operation. A separate record engine does the data movement. This block gives the engine a one-cycle start pulse together with the operation, record offset and record identifier. It then holds busy until the engine's done handshake arrives, and captures the result code the engine returns.

Execution is guarded by a key. A start command runs only when the low byte of the mailbox holds 0x9C. This stops a stray write of the start code from launching an operation.

Top module: `errlog_cmd_if`

## Requirements
- R1: After reset the operation is 0, busy is 0, the command status is 0 (success), the record identifier and record offset are 0, and the mailbox reads 0.
- R2: The command register is at byte offset 0 and the mailbox at byte offset 8. A 64-bit access covers a whole register. A 32-bit access uses the low half when address bit 2 is 0 and the high half when it is 1, and a 32-bit write leaves the other half unchanged. The command register reads back the last word written to it.
- R3: Accesses outside the window are ignored and read as zero. This covers offsets of 16 and above, offsets that are not a multiple of 4, and 64-bit accesses with address bit 2 set.
- R4: Command codes 0x00 (write), 0x01 (read), 0x02 (clear), 0x03 (end) and 0x0B (dummy write) only latch that code as the pending operation.
- R5: Command 0x05 starts the pending operation only when mailbox bits [7:0] equal 0x9C. With any other low byte it changes nothing.
- R6: Starting write, read or clear raises a start pulse that lasts exactly one cycle. Busy stays 1 until the engine's done arrives, and on that edge the engine's result code becomes the command status.
- R7: Starting end or dummy write gives no start pulse and sets the command status to 0 (success). An unknown pending operation gives status 3 (failed). Other codes are 1 not enough space, 2 hardware absent, 4 store empty and 5 not found.
- R8: Command 0x06 copies busy into the mailbox (value 0 or 1). Command 0x07 copies the command status into the mailbox.
- R9: Command 0x04 loads the record offset from mailbox bits [31:0]. Command 0x09 loads the record identifier from the whole mailbox.
- R10: Command 0x10 puts 100 in mailbox bits [63:32] and 10 in bits [31:0]. Command 0x0F clears the mailbox.
- R11: Command writes whose value is not one of the listed codes, including a 64-bit write with any upper bit set, leave the operation, mailbox, offset, identifier, busy and status unchanged.
- R12: While busy, commands 0x00–0x03, 0x0B, 0x04, 0x09 and 0x05 are ignored. Copy commands read the state as it was before the edge, so a copy in the same cycle as done sees busy 1 and the old status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access valid this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr_i | input | 8 | Byte address of the access |
| req_wdata_i | input | 64 | Write data, 32-bit writes use bits [31:0] |
| rd_data_o | output | 64 | Read data, same cycle, zero-extended for 32-bit reads |
| eng_start_o | output | 1 | One-cycle start pulse to the record engine |
| eng_op_o | output | 8 | Pending operation code |
| eng_rec_off_o | output | 32 | Record offset |
| eng_rec_id_o | output | 64 | Record identifier |
| eng_done_i | input | 1 | Engine finished, valid while busy |
| eng_status_i | input | 8 | Engine result code, sampled with done |
| busy_o | output | 1 | Operation in progress |

## Verification
The collision that matters is the engine's done arriving in the same cycle as a software command. The bench holds back its engine model and drives done itself, on the very edge that carries a busy-copy command or a start command. It then judges the result from the ports. The busy copy must read 1 and busy must drop. A later status copy must show the result that arrived with done. A start issued in the done cycle must produce no start pulse and must leave busy low.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  // pending operation codes
  localparam logic [7:0] OP_WRITE = 8'h00;
  localparam logic [7:0] OP_READ  = 8'h01;
  localparam logic [7:0] OP_CLEAR = 8'h02;
  localparam logic [7:0] OP_END   = 8'h03;
  localparam logic [7:0] OP_DUMMY = 8'h0B;
  // command codes
  localparam logic [7:0] CMD_SET_OFF    = 8'h04;
  localparam logic [7:0] CMD_START      = 8'h05;
  localparam logic [7:0] CMD_GET_BUSY   = 8'h06;
  localparam logic [7:0] CMD_GET_STAT   = 8'h07;
  localparam logic [7:0] CMD_SET_ID     = 8'h09;
  localparam logic [7:0] CMD_GET_ATTR   = 8'h0F;
  localparam logic [7:0] CMD_GET_TIMING = 8'h10;
  localparam logic [7:0] START_KEY      = 8'h9C;
  // status codes
  localparam logic [7:0] ST_OK        = 8'h00;
  localparam logic [7:0] ST_NO_SPACE  = 8'h01;
  localparam logic [7:0] ST_HW_ABSENT = 8'h02;
  localparam logic [7:0] ST_FAILED    = 8'h03;
  localparam logic [7:0] ST_EMPTY     = 8'h04;
  localparam logic [7:0] ST_NOT_FOUND = 8'h05;

  typedef struct packed {
    logic latch_op;
    logic set_off;
    logic start;
    logic get_busy;
    logic get_stat;
    logic set_id;
    logic get_zero;
    logic get_timing;
  } cmd_t;
endpackage

// File: rtl/errlog_word_merge.sv
module errlog_word_merge #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wide_i,
  input  logic          hi_i,
  output logic [DW-1:0] merged_o,
  output logic [DW-1:0] rd_lane_o
);
  localparam int HW = DW / 2;

  always_comb begin
    if (wide_i)    merged_o = wdata_i;
    else if (hi_i) merged_o = {wdata_i[HW-1:0], cur_i[HW-1:0]};
    else           merged_o = {cur_i[DW-1:HW], wdata_i[HW-1:0]};
  end

  always_comb begin
    if (wide_i)    rd_lane_o = cur_i;
    else if (hi_i) rd_lane_o = {{HW{1'b0}}, cur_i[DW-1:HW]};
    else           rd_lane_o = {{HW{1'b0}}, cur_i[HW-1:0]};
  end
endmodule

// File: rtl/errlog_cmd_dec.sv
module errlog_cmd_dec
  import errlog_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          wr_i,
  input  logic [DW-1:0] code_i,
  output cmd_t          cmd_o
);
  logic upper_zero;
  assign upper_zero = (code_i[DW-1:8] == '0);

  always_comb begin
    cmd_o = '0;
    if (wr_i && upper_zero) begin
      case (code_i[7:0])
        OP_WRITE, OP_READ, OP_CLEAR, OP_END, OP_DUMMY: cmd_o.latch_op = 1'b1;
        CMD_SET_OFF:    cmd_o.set_off    = 1'b1;
        CMD_START:      cmd_o.start      = 1'b1;
        CMD_GET_BUSY:   cmd_o.get_busy   = 1'b1;
        CMD_GET_STAT:   cmd_o.get_stat   = 1'b1;
        CMD_SET_ID:     cmd_o.set_id     = 1'b1;
        CMD_GET_ATTR:   cmd_o.get_zero   = 1'b1;
        CMD_GET_TIMING: cmd_o.get_timing = 1'b1;
        default:        cmd_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/errlog_exec_ctrl.sv
module errlog_exec_ctrl
  import errlog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] op_i,
  input  logic       done_i,
  input  logic [7:0] eng_status_i,
  output logic       start_o,
  output logic       busy_o,
  output logic [7:0] status_o
);
  logic       start_q, busy_q;
  logic [7:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      busy_q   <= 1'b0;
      status_q <= ST_OK;
    end else begin
      start_q <= 1'b0;
      if (busy_q) begin
        if (done_i) begin
          busy_q   <= 1'b0;
          status_q <= eng_status_i;
        end
      end else if (go_i) begin
        case (op_i)
          OP_WRITE, OP_READ, OP_CLEAR: begin
            start_q <= 1'b1;
            busy_q  <= 1'b1;
          end
          OP_END, OP_DUMMY: status_q <= ST_OK;
          default:          status_q <= ST_FAILED;
        endcase
      end
    end
  end

  assign start_o  = start_q;
  assign busy_o   = busy_q;
  assign status_o = status_q;
endmodule

// File: rtl/errlog_cmd_if.sv
module errlog_cmd_if
  import errlog_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 64,
  parameter int OFF_W    = 32,
  parameter int TIME_MAX = 100,
  parameter int TIME_NOM = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             req_wide_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             eng_start_o,
  output logic [7:0]       eng_op_o,
  output logic [OFF_W-1:0] eng_rec_off_o,
  output logic [DW-1:0]    eng_rec_id_o,
  input  logic             eng_done_i,
  input  logic [7:0]       eng_status_i,
  output logic             busy_o
);
  localparam int HW = DW / 2;
  localparam int NREG = 2;
  localparam logic [DW-1:0] TIMING_WORD = {HW'(TIME_MAX), HW'(TIME_NOM)};

  logic in_win, sel_cmd, sel_val, hi, wr;
  logic [DW-1:0] cmd_q, val_q, id_q;
  logic [OFF_W-1:0] off_q;
  logic [7:0] op_q, status_w;
  logic busy_w, start_w, go_w;
  logic [DW-1:0] code_w;
  cmd_t cmd_w;
  logic [DW-1:0] cur_w [NREG];
  logic [DW-1:0] merged_w [NREG];
  logic [DW-1:0] lane_w [NREG];

  // window decode: 16 aligned bytes, 64-bit accesses on 8-byte boundaries only
  assign in_win  = (req_addr_i[AW-1:4] == '0) && (req_addr_i[1:0] == 2'b00)
                   && !(req_wide_i && req_addr_i[2]);
  assign sel_cmd = in_win && !req_addr_i[3];
  assign sel_val = in_win &&  req_addr_i[3];
  assign hi      = req_addr_i[2];
  assign wr      = req_valid_i && req_write_i;

  assign cur_w[0] = cmd_q;
  assign cur_w[1] = val_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    errlog_word_merge #(.DW(DW)) u_merge (
      .cur_i    (cur_w[g]),
      .wdata_i  (req_wdata_i),
      .wide_i   (req_wide_i),
      .hi_i     (hi),
      .merged_o (merged_w[g]),
      .rd_lane_o(lane_w[g])
    );
  end

  assign code_w = req_wide_i ? req_wdata_i : {{HW{1'b0}}, req_wdata_i[HW-1:0]};

  errlog_cmd_dec #(.DW(DW)) u_dec (
    .wr_i  (wr && sel_cmd && !hi),
    .code_i(code_w),
    .cmd_o (cmd_w)
  );

  assign go_w = cmd_w.start && (val_q[7:0] == START_KEY) && !busy_w;

  errlog_exec_ctrl u_exec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go_w),
    .op_i        (op_q),
    .done_i      (eng_done_i),
    .eng_status_i(eng_status_i),
    .start_o     (start_w),
    .busy_o      (busy_w),
    .status_o    (status_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      val_q <= '0;
      op_q  <= OP_WRITE;
      off_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr && sel_cmd) cmd_q <= merged_w[0];
      if (wr && sel_val)          val_q <= merged_w[1];
      else if (cmd_w.get_busy)    val_q <= {{(DW-1){1'b0}}, busy_w};
      else if (cmd_w.get_stat)    val_q <= {{(DW-8){1'b0}}, status_w};
      else if (cmd_w.get_zero)    val_q <= '0;
      else if (cmd_w.get_timing)  val_q <= TIMING_WORD;
      if (!busy_w) begin
        if (cmd_w.latch_op) op_q  <= code_w[7:0];
        if (cmd_w.set_off)  off_q <= val_q[OFF_W-1:0];
        if (cmd_w.set_id)   id_q  <= val_q;
      end
    end
  end

  assign rd_data_o     = (req_valid_i && !req_write_i && in_win) ? lane_w[req_addr_i[3]] : '0;
  assign eng_start_o   = start_w;
  assign eng_op_o      = op_q;
  assign eng_rec_off_o = off_q;
  assign eng_rec_id_o  = id_q;
  assign busy_o        = busy_w;
endmodule

// File: rtl/errlog_cmd_if_chk.sv
module errlog_cmd_if_chk #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_write_i,
  input logic [AW-1:0] req_addr_i,
  input logic [DW-1:0] req_wdata_i,
  input logic [DW-1:0] rd_data_o,
  input logic          eng_start_o,
  input logic [7:0]    eng_op_o,
  input logic [DW-1:0] eng_rec_id_o,
  input logic          eng_done_i,
  input logic          busy_o
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o); // R6
  AST_START_WITH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> busy_o); // R6
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !eng_done_i |=> busy_o); // R6
  AST_DONE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && eng_done_i |=> !busy_o); // R6
  AST_START_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i && req_write_i && req_addr_i == '0
                            && req_wdata_i[7:0] == 8'h05)); // R5
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !eng_start_o); // R12
  AST_STATE_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(eng_op_o) && $stable(eng_rec_id_o)); // R12
  AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && req_addr_i[AW-1:4] != '0 |-> rd_data_o == '0); // R3
endmodule

bind errlog_cmd_if errlog_cmd_if_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rd_data_o   (rd_data_o),
  .eng_start_o (eng_start_o),
  .eng_op_o    (eng_op_o),
  .eng_rec_id_o(eng_rec_id_o),
  .eng_done_i  (eng_done_i),
  .busy_o      (busy_o)
);

// File: tb/errlog_cmd_if_tb_top.sv
`timescale 1ns/1ps
module errlog_cmd_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rd_data;
  logic        eng_start, busy, eng_done = 1'b0;
  logic [7:0]  eng_op, eng_status = '0;
  logic [31:0] eng_off;
  logic [63:0] eng_id;

  int nchk = 0, nerr = 0;
  bit finished = 0;
  bit auto_eng = 1;
  int eng_lat = 3;
  logic [7:0] eng_res = 8'h01;
  logic [63:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  errlog_cmd_if dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_wide_i(req_wide),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rd_data_o(rd_data),
    .eng_start_o(eng_start), .eng_op_o(eng_op), .eng_rec_off_o(eng_off),
    .eng_rec_id_o(eng_id), .eng_done_i(eng_done), .eng_status_i(eng_status),
    .busy_o(busy)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic w, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wide = w; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_wr_done(input logic [7:0] a, input logic [63:0] d, input logic [7:0] st);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wide = 0; req_wdata = d;
    eng_done = 1; eng_status = st;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; eng_done = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic w, input logic [63:0] e, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_wide = w;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic cmd(input logic [63:0] c); bus_wr(8'h00, 1'b0, c); endtask
  task automatic setv(input logic [63:0] d); bus_wr(8'h08, 1'b1, d); endtask
  task automatic rdv(input logic [63:0] e, input string tag); bus_rd(8'h08, 1'b1, e, tag); endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && busy; i++) @(posedge clk);
    #1;
  endtask

  // monitor: pops expected read data and compares
  initial begin
    forever begin
      @(negedge clk); #3;
      if (req_valid && !req_write) begin
        if (exp_q.size() == 0) chk("monitor underflow", 64'h1, 64'h0);
        else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  // record engine model
  initial begin
    forever begin
      @(negedge clk);
      if (auto_eng && eng_start) begin
        repeat (eng_lat) @(negedge clk);
        eng_status = eng_res; eng_done = 1;
        @(negedge clk);
        eng_done = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 op", {56'b0, eng_op}, 64'h0);
    chk("R1 busy", {63'b0, busy}, 64'h0);
    chk("R1 id", eng_id, 64'h0);
    chk("R1 off", {32'b0, eng_off}, 64'h0);
    rdv(64'h0, "R1 mailbox");
    cmd(64'h07); rdv(64'h0, "R1 status");

    // R2 lanes
    setv(64'h1122334455667788);
    bus_rd(8'h08, 1'b0, 64'h55667788, "R2 low lane");
    bus_rd(8'h0C, 1'b0, 64'h11223344, "R2 high lane");
    bus_wr(8'h0C, 1'b0, 64'hAABBCCDD);
    rdv(64'hAABBCCDD55667788, "R2 high write keeps low");
    bus_wr(8'h08, 1'b0, 64'h01020304);
    rdv(64'hAABBCCDD01020304, "R2 low write keeps high");
    cmd(64'h10);
    bus_rd(8'h00, 1'b0, 64'h10, "R2 command readback");
    bus_rd(8'h04, 1'b0, 64'h0, "R2 command high half");

    // R9 offset and identifier
    setv(64'h0000000100000200); cmd(64'h04);
    chk("R9 offset", {32'b0, eng_off}, 64'h200);
    setv(64'h123456789ABCDEF0); cmd(64'h09);
    chk("R9 identifier", eng_id, 64'h123456789ABCDEF0);

    // R10 fixed words
    cmd(64'h10); rdv(64'h000000640000000A, "R10 timing");
    cmd(64'h0F); rdv(64'h0, "R10 attributes");

    // R4 latch
    cmd(64'h01); chk("R4 read op", {56'b0, eng_op}, 64'h01);
    cmd(64'h0B); chk("R4 dummy op", {56'b0, eng_op}, 64'h0B);
    cmd(64'h03); chk("R4 end op", {56'b0, eng_op}, 64'h03);
    cmd(64'h02); chk("R4 clear op", {56'b0, eng_op}, 64'h02);

    // R11 unknown codes
    cmd(64'h01);
    setv(64'h5555);
    cmd(64'h0C); cmd(64'h08); cmd(64'h11);
    bus_wr(8'h00, 1'b1, 64'h0000000100000003);
    rdv(64'h5555, "R11 mailbox unchanged");
    chk("R11 op unchanged", {56'b0, eng_op}, 64'h01);
    chk("R11 busy unchanged", {63'b0, busy}, 64'h0);
    chk("R11 id unchanged", eng_id, 64'h123456789ABCDEF0);

    // R3 outside window
    bus_wr(8'h10, 1'b1, 64'hFFFF);
    bus_wr(8'h0A, 1'b0, 64'hFFFF);
    bus_wr(8'h0C, 1'b1, 64'hFFFF);
    rdv(64'h5555, "R3 writes ignored");
    bus_rd(8'h10, 1'b1, 64'h0, "R3 read beyond window");
    bus_rd(8'h0C, 1'b1, 64'h0, "R3 misplaced wide read");
    bus_rd(8'h09, 1'b0, 64'h0, "R3 unaligned read");

    // R6 engine operation
    eng_res = 8'h01;
    cmd(64'h00); setv(64'h9C); cmd(64'h05);
    chk("R6 start", {63'b0, eng_start}, 64'h1);
    chk("R6 busy", {63'b0, busy}, 64'h1);
    @(posedge clk); #1;
    chk("R6 start single cycle", {63'b0, eng_start}, 64'h0);
    chk("R6 busy held", {63'b0, busy}, 64'h1);
    wait_idle();
    chk("R6 busy released", {63'b0, busy}, 64'h0);
    cmd(64'h07); rdv(64'h01, "R6 status captured");
    cmd(64'h06); rdv(64'h0, "R8 busy copy idle");

    // R7 end / dummy
    eng_res = 8'h05;
    cmd(64'h02); setv(64'h9C); cmd(64'h05); wait_idle();
    cmd(64'h07); rdv(64'h05, "R6 clear status");
    cmd(64'h03); setv(64'h9C); cmd(64'h05);
    chk("R7 end no start", {62'b0, eng_start, busy}, 64'h0);
    cmd(64'h07); rdv(64'h0, "R7 end success");
    cmd(64'h02); setv(64'h9C); cmd(64'h05); wait_idle();
    cmd(64'h0B); setv(64'h9C); cmd(64'h05);
    chk("R7 dummy no start", {62'b0, eng_start, busy}, 64'h0);
    cmd(64'h07); rdv(64'h0, "R7 dummy success");

    // R5 key
    eng_res = 8'h02;
    cmd(64'h01); setv(64'h19D); cmd(64'h05);
    chk("R5 wrong key ignored", {62'b0, eng_start, busy}, 64'h0);
    setv(64'h9C00); cmd(64'h05);
    chk("R5 key in wrong byte", {62'b0, eng_start, busy}, 64'h0);
    cmd(64'h07); rdv(64'h0, "R5 status unchanged");
    setv(64'hAB9C); cmd(64'h05);
    chk("R5 key low byte starts", {63'b0, busy}, 64'h1);
    wait_idle();
    cmd(64'h07); rdv(64'h02, "R5 result");

    // R12 busy gating and collisions
    auto_eng = 0;
    setv(64'h9C); cmd(64'h05);
    chk("R12 busy", {63'b0, busy}, 64'h1);
    cmd(64'h02); chk("R12 op frozen", {56'b0, eng_op}, 64'h01);
    setv(64'h77); cmd(64'h09);
    chk("R12 id frozen", eng_id, 64'h123456789ABCDEF0);
    setv(64'h9C); cmd(64'h05);
    chk("R12 no restart", {63'b0, eng_start}, 64'h0);
    bus_wr_done(8'h00, 64'h06, 8'h04);
    chk("R12 done clears busy", {63'b0, busy}, 64'h0);
    rdv(64'h1, "R12 busy copy sees pre-edge");
    cmd(64'h07); rdv(64'h04, "R12 status from done");
    setv(64'h9C); cmd(64'h05);
    chk("R12 busy again", {63'b0, busy}, 64'h1);
    bus_wr_done(8'h00, 64'h05, 8'h03);
    chk("R12 start in done cycle ignored", {62'b0, eng_start, busy}, 64'h0);
    @(posedge clk); #1;
    chk("R12 stays idle", {62'b0, eng_start, busy}, 64'h0);
    cmd(64'h07); rdv(64'h03, "R12 status after collision");

    @(negedge clk); #5;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule